// File: doc/BRIEF.md
# Receive Buffer Ring Manager

This block keeps track of a circular table of receive buffer descriptors that lives in external memory. Software programs a start pointer, an end pointer, a read pointer, a write pointer and an upper address segment. On demand, the block reads the next four-word descriptor over a simple word read port. It then loads the current buffer address and the remaining word count, moves the read pointer forward by one entry and wraps it back to the start pointer when it reaches the end pointer. If the read pointer has caught up with the software write pointer, it raises an exhausted flag.

A fetch can be triggered in three ways: a command strobe, software clearing a set exhausted flag, or a low-space condition after a packet has been stored. The packet store path reports how many words it used. When the remaining count falls below a programmable threshold, the next buffer is fetched. If no buffer is left, a halt-reception flag is raised instead. Only one fetch runs at a time, and requests that arrive during a fetch are merged into a single pending fetch.

Top module: `rx_buf_ring`

## Requirements
- R1: A descriptor is four 16-bit words read in this order: address low, address high, count low, count high. After a fetch, `buf_addr` = {word1, word0} and `words_left` = {word3, word2}.
- R2: Word k (k = 0..3) of a fetch is read from {segment, read pointer} + 2k in narrow mode (`wide_mode`=0) or + 4k in wide mode. The words are read in order, one request per word, and the next request waits for `mem_valid`.
- R3: After a fetch the read pointer advances by 8 (narrow) or 16 (wide), modulo 2^16. If the result equals the end pointer, it is replaced by the start pointer.
- R4: After the advance and wrap, if the read pointer equals the write pointer, `exhausted` is set.
- R5: Register codes on `cfg_sel`: 0 start, 1 end, 2 read pointer, 3 write pointer, 4 segment, 5 threshold. Codes 6 and 7 read zero. Writes to codes 0..3 clear bit 0 in narrow mode and bits 1:0 in wide mode. Segment and threshold are stored unmasked. `cfg_rdata` shows the selected register.
- R6: A `cmd_fetch` pulse starts a fetch. `fetch_cmd` is high from the following cycle until the fetch it started completes.
- R7: `exh_clr` while `exhausted` is set clears the flag and starts a fetch. While the flag is clear, `exh_clr` has no effect: no fetch, and `busy` stays low.
- R8: `pkt_done` subtracts `pkt_words` from `words_left`. If the result is below the threshold and the read and write pointers differ, a fetch starts. If the pointers are equal, `halt_rx` is set instead. A result at or above the threshold does nothing more.
- R9: Every completed fetch clears `halt_rx`.
- R10: At most one memory request is outstanding. Requests made during a fetch are merged into one pending fetch that starts after the current one. `busy` is high while a fetch is pending or running.
- R11: After synchronous reset, all pointers and the segment are 0, the threshold is 0x02F8, `buf_addr` and `words_left` are 0, and all flags and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1 = 32-bit bus spacing, 0 = 16-bit |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select for write and readback |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Selected register value |
| cmd_fetch | input | 1 | Fetch command strobe |
| exh_clr | input | 1 | Write-one-to-clear of the exhausted flag |
| pkt_done | input | 1 | A packet has been stored |
| pkt_words | input | 16 | Words consumed by that packet |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| buf_addr | output | 32 | Current buffer address |
| words_left | output | 32 | Remaining word count |
| rd_ptr | output | 16 | Ring read pointer |
| fetch_cmd | output | 1 | Fetch command bit, self-clearing |
| busy | output | 1 | Fetch pending or running |
| exhausted | output | 1 | Buffer-exhausted flag |
| halt_rx | output | 1 | Reception halted, no buffer left |

## Verification
The bench drives the read pointer onto the end pointer so the wrap is exercised in both bus modes. A design that compared before wrapping, or used the wrong stride, would leave the pointer past the end and fetch from the wrong addresses. It clears the exhausted flag when it is set and when it is not; a design that fetched on a clear of an already-clear flag would show `busy` rising and the pointer moving. Low-space events are produced with the pointers equal and with them apart, to separate the halt path from the fetch path. Commands are also issued during slow memory replies; a design that dropped the pending request or let two requests overlap would stop one fetch short or put two requests in flight.

// File: rtl/rbr_pkg.sv
// Shared definitions for the receive buffer ring manager.
// Assumes a descriptor of exactly four words.
package rbr_pkg;
    typedef enum logic [2:0] {
        SEL_BASE   = 3'd0,
        SEL_LIMIT  = 3'd1,
        SEL_RDPTR  = 3'd2,
        SEL_WRPTR  = 3'd3,
        SEL_SEG    = 3'd4,
        SEL_THRESH = 3'd5
    } rbr_sel_e;

    typedef enum logic [1:0] {
        FE_IDLE,
        FE_ISSUE,
        FE_WAIT
    } fe_state_e;

    localparam int unsigned N_PTRS      = 4;
    localparam int unsigned ENTRY_WORDS = 4;
endpackage

// File: rtl/rbr_ptr_regs.sv
// Ring pointer, segment and threshold registers with alignment masking.
// Assumes the read pointer load from the fetch engine wins over a
// software write in the same cycle.
module rbr_ptr_regs
    import rbr_pkg::*;
#(
    parameter int unsigned     DW        = 16,
    parameter logic [DW-1:0]   THR_RESET = 16'h02F8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide,
    input  logic          wr_en,
    input  logic [2:0]    sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          load_rp,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] base,
    output logic [DW-1:0] limit,
    output logic [DW-1:0] rd_ptr,
    output logic [DW-1:0] wr_ptr,
    output logic [DW-1:0] seg,
    output logic [DW-1:0] thresh
);
    logic [DW-1:0] align_mask;
    logic [DW-1:0] ptr_q [N_PTRS];
    logic [DW-1:0] ptr_d [N_PTRS];
    logic [DW-1:0] seg_q;
    logic [DW-1:0] thr_q;

    assign align_mask = wide ? ~DW'(3) : ~DW'(1);

    // Next value of each ring pointer; only the read pointer takes loads
    generate
        for (genvar g = 0; g < N_PTRS; g++) begin : g_ptr
            localparam logic [2:0] MY_SEL = 3'(g);
            if (g == int'(SEL_RDPTR)) begin : g_rd
                assign ptr_d[g] = load_rp ? load_val :
                                  (wr_en && sel == MY_SEL) ? (wr_data & align_mask) :
                                  ptr_q[g];
            end else begin : g_plain
                assign ptr_d[g] = (wr_en && sel == MY_SEL) ? (wr_data & align_mask) :
                                  ptr_q[g];
            end
        end
    endgenerate

    // Pointer storage
    always_ff @(posedge clk) begin
        for (int i = 0; i < N_PTRS; i++) begin
            if (!rst_n) ptr_q[i] <= '0;
            else        ptr_q[i] <= ptr_d[i];
        end
    end

    // Segment and threshold storage, unmasked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= '0;
            thr_q <= THR_RESET;
        end else if (wr_en) begin
            if (sel == SEL_SEG)    seg_q <= wr_data;
            if (sel == SEL_THRESH) thr_q <= wr_data;
        end
    end

    // Readback multiplexer
    always_comb begin
        case (sel)
            SEL_BASE:   rd_data = ptr_q[0];
            SEL_LIMIT:  rd_data = ptr_q[1];
            SEL_RDPTR:  rd_data = ptr_q[2];
            SEL_WRPTR:  rd_data = ptr_q[3];
            SEL_SEG:    rd_data = seg_q;
            SEL_THRESH: rd_data = thr_q;
            default:    rd_data = '0;
        endcase
    end

    assign base   = ptr_q[0];
    assign limit  = ptr_q[1];
    assign rd_ptr = ptr_q[2];
    assign wr_ptr = ptr_q[3];
    assign seg    = seg_q;
    assign thresh = thr_q;

    AST_WRAP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        load_rp |-> (load_val != ptr_q[1] || load_val == ptr_q[0])); // R3
    AST_RD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        load_rp |=> (ptr_q[2][0] == 1'b0)); // R5
endmodule

// File: rtl/rbr_fetch_eng.sv
// Descriptor fetch engine: issues one word request at a time, gathers
// the four descriptor words, computes the advanced and wrapped read
// pointer, and keeps the buffer address and remaining word count.
// Assumes memory returns exactly one mem_valid per request.
module rbr_fetch_eng
    import rbr_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wide,
    input  logic            start,
    input  logic [DW-1:0]   seg,
    input  logic [DW-1:0]   rd_ptr,
    input  logic [DW-1:0]   wr_ptr,
    input  logic [DW-1:0]   base,
    input  logic [DW-1:0]   limit,
    input  logic [DW-1:0]   thresh,
    input  logic            pkt_done,
    input  logic [DW-1:0]   pkt_words,
    output logic            mem_req,
    output logic [2*DW-1:0] mem_addr,
    input  logic            mem_valid,
    input  logic [DW-1:0]   mem_rdata,
    output logic            fe_busy,
    output logic            fe_done,
    output logic            exh_hit,
    output logic            low_space,
    output logic            load_rp,
    output logic [DW-1:0]   load_val,
    output logic [2*DW-1:0] buf_addr,
    output logic [2*DW-1:0] words_left
);
    localparam int unsigned AW = 2 * DW;
    localparam int unsigned IW = $clog2(ENTRY_WORDS);

    fe_state_e       st_q;
    logic [IW-1:0]   idx_q;
    logic [DW-1:0]   cap_q [ENTRY_WORDS-1];
    logic [DW-1:0]   cap_d [ENTRY_WORDS-1];
    logic [DW-1:0]   word_w [ENTRY_WORDS];
    logic            capture;
    logic            last;
    logic [DW-1:0]   stride;
    logic [DW-1:0]   rp_adv;
    logic [DW-1:0]   rp_next;
    logic [AW-1:0]   offs;
    logic [AW-1:0]   buf_q;
    logic [AW-1:0]   cnt_q;
    logic [AW-1:0]   cnt_after;

    assign capture = (st_q == FE_WAIT) && mem_valid;
    assign last    = capture && (idx_q == IW'(ENTRY_WORDS - 1));

    // Word assembly: earlier words from capture registers, the last one live
    generate
        for (genvar g = 0; g < ENTRY_WORDS; g++) begin : g_word
            if (g < ENTRY_WORDS - 1) begin : g_held
                assign cap_d[g]  = (capture && idx_q == IW'(g)) ? mem_rdata : cap_q[g];
                assign word_w[g] = cap_q[g];
            end else begin : g_live
                assign word_w[g] = mem_rdata;
            end
        end
    endgenerate

    // Capture registers for the leading descriptor words
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRY_WORDS - 1; i++) begin
            if (!rst_n) cap_q[i] <= '0;
            else        cap_q[i] <= cap_d[i];
        end
    end

    // Request sequencing: idle, issue one word, wait for its data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= FE_IDLE;
            idx_q <= '0;
        end else begin
            case (st_q)
                FE_IDLE: begin
                    if (start) begin
                        st_q  <= FE_ISSUE;
                        idx_q <= '0;
                    end
                end
                FE_ISSUE: st_q <= FE_WAIT;
                FE_WAIT: begin
                    if (last) begin
                        st_q <= FE_IDLE;
                    end else if (capture) begin
                        st_q  <= FE_ISSUE;
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: st_q <= FE_IDLE;
            endcase
        end
    end

    // Address of the current word and the pointer after this entry
    always_comb begin
        offs     = wide ? (AW'(idx_q) << 2) : (AW'(idx_q) << 1);
        mem_addr = {seg, rd_ptr} + offs;
        stride   = wide ? DW'(4 * ENTRY_WORDS) : DW'(2 * ENTRY_WORDS);
        rp_adv   = rd_ptr + stride;
        rp_next  = (rp_adv == limit) ? base : rp_adv;
    end

    assign cnt_after = cnt_q - AW'(pkt_words);

    // Buffer address and remaining count: load on fetch, shrink per packet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            cnt_q <= '0;
        end else if (last) begin
            buf_q <= {word_w[1], word_w[0]};
            cnt_q <= {word_w[3], word_w[2]};
        end else if (pkt_done) begin
            cnt_q <= cnt_after;
        end
    end

    assign mem_req    = (st_q == FE_ISSUE);
    assign fe_busy    = (st_q != FE_IDLE);
    assign fe_done    = last;
    assign load_rp    = last;
    assign load_val   = rp_next;
    assign exh_hit    = last && (rp_next == wr_ptr);
    assign low_space  = pkt_done && !last && (cnt_after < AW'(thresh));
    assign buf_addr   = buf_q;
    assign words_left = cnt_q;

    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R10
    AST_DATA_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> (st_q == FE_WAIT)); // R2
endmodule

// File: rtl/rbr_req_ctl.sv
// Request merging and status flags: merges the three fetch sources
// into one pending bit, starts the engine when idle, and keeps the
// command bit, the exhausted flag and the halt flag.
// Assumes the engine reports completion with a one-cycle fe_done.
module rbr_req_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_fetch,
    input  logic exh_clr,
    input  logic low_space,
    input  logic ptr_eq,
    input  logic fe_busy,
    input  logic fe_done,
    input  logic exh_hit,
    output logic start,
    output logic busy,
    output logic fetch_cmd,
    output logic exhausted,
    output logic halt_rx
);
    logic pend_q;
    logic served_q;
    logic cmd_q;
    logic exh_q;
    logic halt_q;
    logic new_req;

    assign new_req = cmd_fetch | (exh_clr & exh_q) | (low_space & ~ptr_eq);
    assign start   = pend_q & ~fe_busy;

    // Pending request bit, merged across sources
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q & ~start) | new_req;
    end

    // Command bit, cleared by completion of the fetch it was served by
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= 1'b0;
            served_q <= 1'b0;
        end else begin
            if (start)                    served_q <= cmd_q;
            if (cmd_fetch)                cmd_q    <= 1'b1;
            else if (fe_done && served_q) cmd_q    <= 1'b0;
        end
    end

    // Exhausted flag: set by the ring check, write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)       exh_q <= 1'b0;
        else if (exh_hit) exh_q <= 1'b1;
        else if (exh_clr) exh_q <= 1'b0;
    end

    // Halt flag: set on low space with no buffer left, cleared by a fetch
    always_ff @(posedge clk) begin
        if (!rst_n)                     halt_q <= 1'b0;
        else if (fe_done)               halt_q <= 1'b0;
        else if (low_space && ptr_eq)   halt_q <= 1'b1;
    end

    assign busy      = pend_q | fe_busy;
    assign fetch_cmd = cmd_q;
    assign exhausted = exh_q;
    assign halt_rx   = halt_q;

    AST_HALT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        fe_done |=> !halt_rx); // R9
    AST_EXH_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        exh_hit |=> exhausted); // R4
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q && !fe_done) |=> cmd_q); // R6
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> fe_busy); // R10
endmodule

// File: rtl/rx_buf_ring.sv
// Receive buffer ring manager top: ties the register file, the fetch
// engine and the request controller together.
// Assumes pkt_done is not raised in the cycle a fetch completes.
module rx_buf_ring #(
    parameter int unsigned   DW        = 16,
    parameter logic [DW-1:0] THR_RESET = 16'h02F8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wide_mode,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_sel,
    input  logic [DW-1:0]   cfg_wdata,
    output logic [DW-1:0]   cfg_rdata,
    input  logic            cmd_fetch,
    input  logic            exh_clr,
    input  logic            pkt_done,
    input  logic [DW-1:0]   pkt_words,
    output logic            mem_req,
    output logic [2*DW-1:0] mem_addr,
    input  logic            mem_valid,
    input  logic [DW-1:0]   mem_rdata,
    output logic [2*DW-1:0] buf_addr,
    output logic [2*DW-1:0] words_left,
    output logic [DW-1:0]   rd_ptr,
    output logic            fetch_cmd,
    output logic            busy,
    output logic            exhausted,
    output logic            halt_rx
);
    logic [DW-1:0] base, limit, rp, wp, seg, thresh, load_val;
    logic          load_rp, start, fe_busy, fe_done, exh_hit, low_space;

    rbr_ptr_regs #(.DW(DW), .THR_RESET(THR_RESET)) i_regs (
        .clk(clk), .rst_n(rst_n), .wide(wide_mode),
        .wr_en(cfg_we), .sel(cfg_sel), .wr_data(cfg_wdata), .rd_data(cfg_rdata),
        .load_rp(load_rp), .load_val(load_val),
        .base(base), .limit(limit), .rd_ptr(rp), .wr_ptr(wp),
        .seg(seg), .thresh(thresh)
    );

    rbr_fetch_eng #(.DW(DW)) i_fetch (
        .clk(clk), .rst_n(rst_n), .wide(wide_mode), .start(start),
        .seg(seg), .rd_ptr(rp), .wr_ptr(wp), .base(base), .limit(limit),
        .thresh(thresh), .pkt_done(pkt_done), .pkt_words(pkt_words),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .fe_busy(fe_busy), .fe_done(fe_done), .exh_hit(exh_hit),
        .low_space(low_space), .load_rp(load_rp), .load_val(load_val),
        .buf_addr(buf_addr), .words_left(words_left)
    );

    rbr_req_ctl i_ctl (
        .clk(clk), .rst_n(rst_n), .cmd_fetch(cmd_fetch), .exh_clr(exh_clr),
        .low_space(low_space), .ptr_eq(rp == wp), .fe_busy(fe_busy),
        .fe_done(fe_done), .exh_hit(exh_hit), .start(start), .busy(busy),
        .fetch_cmd(fetch_cmd), .exhausted(exhausted), .halt_rx(halt_rx)
    );

    assign rd_ptr = rp;

    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R10
endmodule

// File: tb/test_rx_buf_ring.sv
module test_rx_buf_ring;
    localparam int PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wide_mode = 0;
    logic        cfg_we = 0;
    logic [2:0]  cfg_sel = 0;
    logic [15:0] cfg_wdata = 0;
    logic [15:0] cfg_rdata;
    logic        cmd_fetch = 0, exh_clr = 0, pkt_done = 0;
    logic [15:0] pkt_words = 0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid = 0;
    logic [15:0] mem_rdata = 0;
    logic [31:0] buf_addr, words_left;
    logic [15:0] rd_ptr;
    logic        fetch_cmd, busy, exhausted, halt_rx;

    int checks = 0;
    int errors = 0;
    int mem_lat = 1;
    int cyc = 0;

    rx_buf_ring i_rx_buf_ring (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cmd_fetch(cmd_fetch), .exh_clr(exh_clr), .pkt_done(pkt_done),
        .pkt_words(pkt_words), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .buf_addr(buf_addr),
        .words_left(words_left), .rd_ptr(rd_ptr), .fetch_cmd(fetch_cmd),
        .busy(busy), .exhausted(exhausted), .halt_rx(halt_rx)
    );

    always #(PERIOD/2) clk = ~clk;

    // External memory contents: explicit entries or an address hash
    logic [15:0] mem [logic [31:0]];
    function automatic logic [15:0] mem_word(logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a[15:0] ^ a[31:16] ^ 16'h5A3C;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Memory responder: answers each request after mem_lat cycles
    initial begin
        logic [31:0] a;
        int cnt;
        a = 0; cnt = 0;
        forever begin
            @(negedge clk);
            mem_valid = 0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_valid = 1;
                    mem_rdata = mem_word(a);
                end
            end
            if (mem_req) begin
                a = mem_addr;
                cnt = mem_lat;
            end
        end
    end

    // Reference model state
    logic [15:0] m_ptr [4];
    logic [15:0] m_seg, m_thr;
    logic [31:0] m_buf, m_cnt;
    bit m_exh, m_halt, m_cmd, m_served, m_pend, m_active;
    logic [15:0] m_q [$];

    function automatic logic [15:0] model_rd(logic [2:0] s);
        if (s < 4) return m_ptr[s];
        if (s == 4) return m_seg;
        if (s == 5) return m_thr;
        return 16'h0;
    endfunction

    // Model update on each edge from inputs only, then compare outputs
    always @(posedge clk) begin
        bit done, new_req, o_exh, hit, low;
        logic [15:0] o_rd, o_wr, nr, msk;
        logic [31:0] nc;
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_ptr[i] = 0;
            m_seg = 0; m_thr = 16'h02F8; m_buf = 0; m_cnt = 0;
            m_exh = 0; m_halt = 0; m_cmd = 0; m_served = 0; m_pend = 0; m_active = 0;
            m_q.delete();
        end else begin
            done = 0; new_req = 0; hit = 0; low = 0;
            o_rd = m_ptr[2]; o_wr = m_ptr[3]; o_exh = m_exh;
            if (m_active && mem_valid) begin
                m_q.push_back(mem_rdata);
                if (m_q.size() == 4) begin
                    done = 1;
                    m_active = 0;
                    m_buf = {m_q[1], m_q[0]};
                    m_cnt = {m_q[3], m_q[2]};
                    nr = o_rd + (wide_mode ? 16'd16 : 16'd8);
                    if (nr == m_ptr[1]) nr = m_ptr[0];
                    hit = (nr == o_wr);
                    m_ptr[2] = nr;
                end
            end else if (!m_active && m_pend) begin
                m_active = 1; m_pend = 0; m_served = m_cmd; m_q.delete();
            end
            if (cmd_fetch) begin m_cmd = 1; new_req = 1; end
            else if (done && m_served) m_cmd = 0;
            if (exh_clr && o_exh) new_req = 1;
            if (pkt_done && !done) begin
                nc = m_cnt - {16'h0, pkt_words};
                m_cnt = nc;
                if (nc < {16'h0, m_thr}) begin
                    if (o_rd != o_wr) new_req = 1;
                    else low = 1;
                end
            end
            if (hit) m_exh = 1; else if (exh_clr) m_exh = 0;
            if (done) m_halt = 0; else if (low) m_halt = 1;
            if (cfg_we) begin
                msk = wide_mode ? 16'hFFFC : 16'hFFFE;
                if (cfg_sel < 4) begin
                    if (!(cfg_sel == 2 && done)) m_ptr[cfg_sel] = cfg_wdata & msk;
                end
                else if (cfg_sel == 4) m_seg = cfg_wdata;
                else if (cfg_sel == 5) m_thr = cfg_wdata;
            end
            if (new_req) m_pend = 1;
        end
        #(PERIOD/4);
        if (rst_n) begin
            chk("R1", "buf_addr", buf_addr, m_buf);
            chk("R1", "words_left", words_left, m_cnt);
            chk("R3", "rd_ptr", {16'h0, rd_ptr}, {16'h0, m_ptr[2]});
            chk("R4", "exhausted", {31'h0, exhausted}, {31'h0, m_exh});
            chk("R5", "cfg_rdata", {16'h0, cfg_rdata}, {16'h0, model_rd(cfg_sel)});
            chk("R6", "fetch_cmd", {31'h0, fetch_cmd}, {31'h0, m_cmd});
            chk("R8", "halt_rx", {31'h0, halt_rx}, {31'h0, m_halt});
            chk("R10", "busy", {31'h0, busy}, {31'h0, (m_pend | m_active)});
            if (mem_req) begin
                chk("R10", "req_when_active", {31'h0, m_active}, 32'h1);
                chk("R2", "mem_addr", mem_addr,
                    {m_seg, m_ptr[2]} + 32'(m_q.size()) * (wide_mode ? 32'd4 : 32'd2));
            end
        end
    end

    task automatic cfg_write(logic [2:0] s, logic [15:0] v);
        @(negedge clk);
        cfg_we = 1; cfg_sel = s; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic pulse_cmd();
        @(negedge clk); cmd_fetch = 1;
        @(negedge clk); cmd_fetch = 0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); exh_clr = 1;
        @(negedge clk); exh_clr = 0;
    endtask

    task automatic pulse_pkt(logic [15:0] w);
        @(negedge clk); pkt_done = 1; pkt_words = w;
        @(negedge clk); pkt_done = 0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        @(negedge clk);
        while (busy && n < 2000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic put_entry(logic [31:0] a, int step, logic [15:0] w0, logic [15:0] w1,
                             logic [15:0] w2, logic [15:0] w3);
        mem[a] = w0; mem[a + step] = w1; mem[a + 2*step] = w2; mem[a + 3*step] = w3;
    endtask

    // Watchdog: a hung run is a failed check
    always @(posedge clk) begin
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        put_entry(32'h0002_0100, 2, 16'h4000, 16'h0012, 16'h0400, 16'h0000);
        put_entry(32'h0002_0108, 2, 16'h5000, 16'h0012, 16'h0300, 16'h0000);
        put_entry(32'h0002_0110, 2, 16'h6000, 16'h0012, 16'h0010, 16'h0000);
        put_entry(32'h0002_0118, 2, 16'h7000, 16'h0012, 16'h0800, 16'h0000);
        put_entry(32'h0002_0200, 4, 16'h1111, 16'h0022, 16'h0900, 16'h0000);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "rd_ptr", {16'h0, rd_ptr}, 32'h0);
        chk("R11", "flags", {28'h0, busy, exhausted, halt_rx, fetch_cmd}, 32'h0);
        chk("R11", "buf_addr", buf_addr, 32'h0);
        chk("R11", "words_left", words_left, 32'h0);
        cfg_sel = 3'd5; @(negedge clk);
        chk("R11", "thresh", {16'h0, cfg_rdata}, 32'h02F8);

        // R5 narrow masking
        cfg_write(3'd0, 16'h0101);
        chk("R5", "base_mask", {16'h0, cfg_rdata}, 32'h0100);
        cfg_write(3'd1, 16'h0120);
        cfg_write(3'd2, 16'h0100);
        cfg_write(3'd3, 16'h0118);
        cfg_write(3'd4, 16'h0002);
        cfg_write(3'd6, 16'hBEEF);
        chk("R5", "unused_code", {16'h0, cfg_rdata}, 32'h0);

        // R6 command fetch
        pulse_cmd();
        chk("R6", "cmd_bit_set", {31'h0, fetch_cmd}, 32'h1);
        wait_idle();
        chk("R1", "buf_first", buf_addr, 32'h0012_4000);
        chk("R1", "cnt_first", words_left, 32'h0000_0400);
        chk("R3", "rd_advance", {16'h0, rd_ptr}, 32'h0108);
        chk("R6", "cmd_bit_clear", {31'h0, fetch_cmd}, 32'h0);

        // R8 not below threshold: no fetch
        pulse_pkt(16'h0100);
        repeat (3) @(negedge clk);
        chk("R8", "no_fetch_busy", {31'h0, busy}, 32'h0);
        chk("R8", "cnt_sub", words_left, 32'h0300);
        // R8 below threshold with space: fetch
        pulse_pkt(16'h0010);
        wait_idle();
        chk("R8", "lowspace_fetch", {16'h0, rd_ptr}, 32'h0110);
        chk("R1", "cnt_second", words_left, 32'h0300);

        // R4 exhausted on reaching write pointer
        mem_lat = 2;
        pulse_cmd();
        wait_idle();
        chk("R4", "exh_set", {31'h0, exhausted}, 32'h1);
        // R7 clear when set fetches; R3 wrap to start
        pulse_clr();
        wait_idle();
        chk("R3", "wrap", {16'h0, rd_ptr}, 32'h0100);
        chk("R7", "exh_cleared", {31'h0, exhausted}, 32'h0);
        chk("R1", "cnt_wrap", words_left, 32'h0800);
        // R7 clear when not set: no effect
        pulse_clr();
        chk("R7", "no_fetch", {31'h0, busy}, 32'h0);
        repeat (2) @(negedge clk);
        chk("R7", "ptr_kept", {16'h0, rd_ptr}, 32'h0100);

        // R8 halt when pointers equal
        cfg_write(3'd3, 16'h0100);
        pulse_pkt(16'h0600);
        repeat (2) @(negedge clk);
        chk("R8", "halt_set", {31'h0, halt_rx}, 32'h1);
        chk("R8", "halt_no_fetch", {31'h0, busy}, 32'h0);
        // R9 fetch clears halt
        pulse_cmd();
        wait_idle();
        chk("R9", "halt_clear", {31'h0, halt_rx}, 32'h0);

        // R10 command during a slow fetch becomes pending
        mem_lat = 3;
        pulse_cmd();
        repeat (2) @(negedge clk);
        cmd_fetch = 1; @(negedge clk); cmd_fetch = 0;
        wait_idle();
        chk("R10", "pending_served", {16'h0, rd_ptr}, 32'h0118);

        // Threshold write, count stays above
        cfg_write(3'd5, 16'h0008);
        pulse_pkt(16'h0004);
        repeat (2) @(negedge clk);
        chk("R8", "above_new_thr", {31'h0, busy}, 32'h0);

        // R2/R5 wide mode
        @(negedge clk); wide_mode = 1;
        cfg_write(3'd0, 16'h0202);
        chk("R5", "wide_mask", {16'h0, cfg_rdata}, 32'h0200);
        cfg_write(3'd1, 16'h0230);
        cfg_write(3'd2, 16'h0201);
        cfg_write(3'd3, 16'h0220);
        mem_lat = 1;
        pulse_cmd();
        wait_idle();
        chk("R1", "wide_buf", buf_addr, 32'h0022_1111);
        chk("R3", "wide_stride", {16'h0, rd_ptr}, 32'h0210);
        pulse_cmd();
        wait_idle();
        chk("R4", "wide_exh", {31'h0, exhausted}, 32'h1);
        pulse_clr();
        wait_idle();
        chk("R3", "wide_wrap", {16'h0, rd_ptr}, 32'h0200);

        // Mixed traffic against the model
        cfg_write(3'd5, 16'h02F8);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            mem_lat   = 1 + int'($urandom % 3);
            cmd_fetch = ($urandom % 13) == 0;
            exh_clr   = ($urandom % 11) == 0;
            pkt_done  = ($urandom % 7) == 0;
            pkt_words = 16'($urandom % 64);
            cfg_sel   = 3'($urandom % 8);
        end
        @(negedge clk);
        cmd_fetch = 0; exh_clr = 0; pkt_done = 0;
        wait_idle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule